// File: doc/BRIEF.md
# Memory version tag checker

This block guards a small on-chip tagged memory region. Each 64-byte line of the region has a 4-bit version tag. Loads and stores present a pointer whose top four bits carry a tag. When checking is switched on for the access, the block compares that tag with the one stored for the line. It then either grants the access or reports one of three trap kinds, each with a type code. The same request port also carries tag-set requests, which write a new tag into one line, and block-initialise requests, which clear a line's tag.

Every valid request is accepted in the cycle it is presented, and a registered response follows one clock later. A precise trap stops the access. A disrupting error lets the store complete and records the first offending address in a sticky register. Software reads that register and clears it. Tag writes are allowed only when both the task-level enable and the page-level enable are set, and only on a writable page.

Top module: `tag_guard`

## Requirements
- R1: After synchronous active-low reset, `rsp_valid` and `err_vld` are 0 and every stored tag is 0.
- R2: A request with `req_valid`=1 produces `rsp_valid`=1 exactly one cycle later, and `rsp_addr` echoes its address. A cycle with no request produces `rsp_valid`=0 one cycle later.
- R3: A load (`req_kind`=0) or store (`req_kind`=1) is checked only when `req_task_en`=1 and `req_page_en`=1. Otherwise it gets `rsp_code`=0 (grant), `rsp_grant`=1, `rsp_type`=0x00.
- R4: The pointer tag is `req_addr[63:60]`. If the pointer tag or the stored tag is 0x0 or 0xF, the access never mismatches.
- R5: A checked store mismatch with `req_precise`=0 gives `rsp_code`=2 (disrupting), `rsp_grant`=1 and `rsp_type`=0x7E.
- R6: A checked store mismatch with `req_precise`=1 gives `rsp_code`=1 (precise), `rsp_grant`=0 and `rsp_type`=0x1A.
- R7: A checked load mismatch always gives `rsp_code`=1, `rsp_grant`=0 and `rsp_type`=0x1A, whatever `req_precise` is.
- R8: A non-faulting load (`req_kind`=2) is never checked and always gets `rsp_code`=0.
- R9: A tag-set (`req_kind`=3) with `req_task_en`=0 gives `rsp_code`=3 (disabled), `rsp_grant`=0 and `rsp_type`=0x0A. The stored tag is left unchanged.
- R10: A tag-set with `req_page_ro`=1 or `req_page_en`=0, or a block-initialise with `req_page_ro`=1, gives `rsp_code`=4 (rejected), `rsp_grant`=0 and `rsp_type`=0x00. The stored tag is left unchanged.
- R11: An accepted tag-set writes `req_tag` to the line, and a block-initialise (`req_kind`=4) writes 0 to it. Both give `rsp_code`=0, and a request in the next cycle sees the new tag.
- R12: The line is selected by `req_addr[11:6]`. Bits 63:60, bits 59:12 and bits 5:0 do not affect which line is selected.
- R13: A disrupting error sets `err_vld` and latches its address into `err_addr` only if `err_vld` is 0 or `err_clr` is 1 in that cycle. Later errors do not overwrite it. `err_clr` alone clears `err_vld`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_kind | input | 3 | 0 load, 1 store, 2 non-faulting load, 3 tag-set, 4 block-initialise |
| req_addr | input | 64 | Pointer; bits 63:60 are the version tag |
| req_tag | input | 4 | Tag value for a tag-set |
| req_task_en | input | 1 | Task-level checking enable |
| req_page_en | input | 1 | Page-level checking enable |
| req_page_ro | input | 1 | Page is read-only |
| req_precise | input | 1 | Report store mismatches precisely |
| err_clr | input | 1 | Clear the sticky error record |
| rsp_valid | output | 1 | Response present |
| rsp_code | output | 3 | 0 grant, 1 precise, 2 disrupting, 3 disabled, 4 rejected |
| rsp_grant | output | 1 | Access may complete |
| rsp_type | output | 8 | Trap type or fault type code |
| rsp_addr | output | 64 | Address of the answered request |
| err_vld | output | 1 | Sticky disrupting error present |
| err_addr | output | 64 | Address of the first disrupting error |

## Verification
Loads and stores are run with a matching tag, with a mismatching tag, and with wildcard tags on the pointer side and on the stored side. This separates the compare from the wildcard rule. The same mismatch is repeated with the precise bit set and clear, once for loads and once for stores, so that the choice of trap type follows the access kind. Tag-sets are tried with the task enable off, on a read-only page and with the page enable off, and a load then reads the line back, which shows that each refusal leaves the tag unchanged. Pointers that differ only outside bits 11:6, together with back-to-back disrupting stores and a clear, show the line aliasing and that the sticky register keeps the first address.

// File: rtl/tagchk_pkg.sv
// Shared types for the memory version tag checker.
// Assumes the request kind and response code travel as 3-bit fields.
package tagchk_pkg;

    typedef enum logic [2:0] {
        ACC_LOAD    = 3'd0,
        ACC_STORE   = 3'd1,
        ACC_NFLOAD  = 3'd2,
        ACC_TAGSET  = 3'd3,
        ACC_BLKINIT = 3'd4
    } acc_kind_e;

    typedef enum logic [2:0] {
        RES_GRANT    = 3'd0,
        RES_PRECISE  = 3'd1,
        RES_DISRUPT  = 3'd2,
        RES_DISABLED = 3'd3,
        RES_REJECT   = 3'd4
    } res_code_e;

    localparam logic [7:0] TT_PRECISE  = 8'h1A;
    localparam logic [7:0] TT_DISRUPT  = 8'h7E;
    localparam logic [7:0] FT_DISABLED = 8'h0A;

    typedef struct packed {
        res_code_e  code;
        logic       grant;
        logic [7:0] ttype;
        logic       wr_en;
        logic       disrupt;
    } verdict_t;

endpackage

// File: rtl/tag_store.sv
// Tag array: one TAG_W-bit tag per line, one read port and one write port.
// Assumes at most one write per cycle. The read is combinational, so a
// write becomes visible to a read in the following cycle.
module tag_store #(
    parameter int TAG_W = 4,
    parameter int LINES = 64,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [TAG_W-1:0] rd_tag,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag
);
    logic [TAG_W-1:0] mem [LINES];

    // Clear every tag on reset; otherwise apply the single write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < LINES; i++) mem[i] <= '0;
        end else if (wr_en) begin
            mem[wr_idx] <= wr_tag;
        end
    end

    // Present the addressed tag.
    assign rd_tag = mem[rd_idx];

endmodule

// File: rtl/tag_judge.sv
// Combinational decision for one request: grant or trap, and any tag write.
// Assumes the line tag was read for the request's own line this cycle.
module tag_judge
    import tagchk_pkg::*;
#(
    parameter int TAG_W = 4
) (
    input  acc_kind_e        kind,
    input  logic             task_en,
    input  logic             page_en,
    input  logic             page_ro,
    input  logic             precise,
    input  logic [TAG_W-1:0] ptr_tag,
    input  logic [TAG_W-1:0] line_tag,
    input  logic [TAG_W-1:0] set_tag,
    output verdict_t         vd,
    output logic [TAG_W-1:0] wr_tag
);
    logic ptr_wild, line_wild, miss, checked;

    // Reserved values (all zeros, all ones) act as wildcards on either side.
    always_comb begin
        ptr_wild  = (ptr_tag == '0) || (ptr_tag == '1);
        line_wild = (line_tag == '0) || (line_tag == '1);
        miss      = !ptr_wild && !line_wild && (ptr_tag != line_tag);
        checked   = task_en && page_en;
    end

    // Pick the response and write action for the access kind.
    always_comb begin
        vd         = '0;
        vd.code    = RES_GRANT;
        vd.grant   = 1'b1;
        wr_tag     = set_tag;
        unique case (kind)
            ACC_LOAD: begin
                if (checked && miss) begin
                    vd.code  = RES_PRECISE;
                    vd.grant = 1'b0;
                    vd.ttype = TT_PRECISE;
                end
            end
            ACC_STORE: begin
                if (checked && miss) begin
                    if (precise) begin
                        vd.code  = RES_PRECISE;
                        vd.grant = 1'b0;
                        vd.ttype = TT_PRECISE;
                    end else begin
                        vd.code    = RES_DISRUPT;
                        vd.ttype   = TT_DISRUPT;
                        vd.disrupt = 1'b1;
                    end
                end
            end
            ACC_TAGSET: begin
                if (!task_en) begin
                    vd.code  = RES_DISABLED;
                    vd.grant = 1'b0;
                    vd.ttype = FT_DISABLED;
                end else if (page_ro || !page_en) begin
                    vd.code  = RES_REJECT;
                    vd.grant = 1'b0;
                end else begin
                    vd.wr_en = 1'b1;
                end
            end
            ACC_BLKINIT: begin
                wr_tag = '0;
                if (page_ro) begin
                    vd.code  = RES_REJECT;
                    vd.grant = 1'b0;
                end else begin
                    vd.wr_en = 1'b1;
                end
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/err_latch.sv
// Sticky record of the first disrupting error address.
// Assumes a set in the same cycle as a clear starts a fresh record.
module err_latch #(
    parameter int ADDR_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set,
    input  logic [ADDR_W-1:0] set_addr,
    input  logic              clr,
    output logic              vld,
    output logic [ADDR_W-1:0] addr
);
    // Capture only into an empty (or just cleared) record; clear on request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld  <= 1'b0;
            addr <= '0;
        end else if (set && (!vld || clr)) begin
            vld  <= 1'b1;
            addr <= set_addr;
        end else if (clr) begin
            vld  <= 1'b0;
        end
    end

endmodule

// File: rtl/tag_guard.sv
// Memory version tag checker top: looks up the line tag, decides the
// outcome, writes tags and registers a response one cycle after each request.
// Assumes one request per cycle at most and no back-pressure.
module tag_guard
    import tagchk_pkg::*;
#(
    parameter int ADDR_W    = 64,
    parameter int TAG_W     = 4,
    parameter int LINE_BITS = 6,
    parameter int LINES     = 64,
    localparam int IDX_W    = $clog2(LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [2:0]        req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [TAG_W-1:0]  req_tag,
    input  logic              req_task_en,
    input  logic              req_page_en,
    input  logic              req_page_ro,
    input  logic              req_precise,
    input  logic              err_clr,
    output logic              rsp_valid,
    output logic [2:0]        rsp_code,
    output logic              rsp_grant,
    output logic [7:0]        rsp_type,
    output logic [ADDR_W-1:0] rsp_addr,
    output logic              err_vld,
    output logic [ADDR_W-1:0] err_addr
);
    logic [IDX_W-1:0] line_idx;
    logic [TAG_W-1:0] ptr_tag, line_tag, wr_tag;
    verdict_t         vd;

    // Split the pointer into line index and version tag.
    assign line_idx = req_addr[LINE_BITS +: IDX_W];
    assign ptr_tag  = req_addr[ADDR_W-1 -: TAG_W];

    tag_store #(.TAG_W(TAG_W), .LINES(LINES)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_idx (line_idx),
        .rd_tag (line_tag),
        .wr_en  (req_valid && vd.wr_en),
        .wr_idx (line_idx),
        .wr_tag (wr_tag)
    );

    tag_judge #(.TAG_W(TAG_W)) u_judge (
        .kind     (acc_kind_e'(req_kind)),
        .task_en  (req_task_en),
        .page_en  (req_page_en),
        .page_ro  (req_page_ro),
        .precise  (req_precise),
        .ptr_tag  (ptr_tag),
        .line_tag (line_tag),
        .set_tag  (req_tag),
        .vd       (vd),
        .wr_tag   (wr_tag)
    );

    err_latch #(.ADDR_W(ADDR_W)) u_err (
        .clk      (clk),
        .rst_n    (rst_n),
        .set      (req_valid && vd.disrupt),
        .set_addr (req_addr),
        .clr      (err_clr),
        .vld      (err_vld),
        .addr     (err_addr)
    );

    // Register the verdict so the response appears one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_code  <= RES_GRANT;
            rsp_grant <= 1'b0;
            rsp_type  <= '0;
            rsp_addr  <= '0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                rsp_code  <= vd.code;
                rsp_grant <= vd.grant;
                rsp_type  <= vd.ttype;
                rsp_addr  <= req_addr;
            end
        end
    end

endmodule

// File: rtl/tag_guard_chk.sv
// Property checker for tag_guard, attached by bind. Observes ports only.
module tag_guard_chk
    import tagchk_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int TAG_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [2:0]        req_kind,
    input logic [ADDR_W-1:0] req_addr,
    input logic              req_task_en,
    input logic              req_page_en,
    input logic              err_clr,
    input logic              rsp_valid,
    input logic [2:0]        rsp_code,
    input logic [7:0]        rsp_type,
    input logic              err_vld,
    input logic [ADDR_W-1:0] err_addr
);
    logic is_ldst, wild_ptr;
    assign is_ldst  = (req_kind == 3'd0) || (req_kind == 3'd1);
    assign wild_ptr = (req_addr[ADDR_W-1 -: TAG_W] == '0) || (req_addr[ADDR_W-1 -: TAG_W] == '1);

    AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid); // R2
    AST_NO_RSP_WITHOUT_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid); // R2
    AST_UNCHECKED_GRANTED: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && is_ldst && !(req_task_en && req_page_en) |=> rsp_code == 3'd0); // R3
    AST_WILD_PTR_GRANTED: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && is_ldst && wild_ptr |=> rsp_code == 3'd0); // R4
    AST_LOAD_NEVER_DEFERRED: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_kind == 3'd0 |=> rsp_code != 3'd2); // R7
    AST_NFLOAD_GRANTED: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_kind == 3'd2 |=> rsp_code == 3'd0); // R8
    AST_DISABLED_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_code == 3'd3 |-> rsp_type == 8'h0A); // R9
    AST_STICKY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        err_vld && !err_clr |=> err_vld && $stable(err_addr)); // R13

endmodule

bind tag_guard tag_guard_chk #(.ADDR_W(ADDR_W), .TAG_W(TAG_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_kind    (req_kind),
    .req_addr    (req_addr),
    .req_task_en (req_task_en),
    .req_page_en (req_page_en),
    .err_clr     (err_clr),
    .rsp_valid   (rsp_valid),
    .rsp_code    (rsp_code),
    .rsp_type    (rsp_type),
    .err_vld     (err_vld),
    .err_addr    (err_addr)
);

// File: tb/sim_tag_guard.sv
// Bench for tag_guard: behavioural reference model compared every clock.
module sim_tag_guard;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_kind = 3'd0;
    logic [63:0] req_addr = '0;
    logic [3:0]  req_tag = '0;
    logic        req_task_en = 1'b0, req_page_en = 1'b0, req_page_ro = 1'b0, req_precise = 1'b0;
    logic        err_clr = 1'b0;
    logic        rsp_valid, rsp_grant, err_vld;
    logic [2:0]  rsp_code;
    logic [7:0]  rsp_type;
    logic [63:0] rsp_addr, err_addr;

    int checks = 0, fails = 0, cycles = 0;
    bit done = 0;

    int          m_tag [64];
    bit          m_evld = 0;
    logic [63:0] m_eaddr = '0;

    tag_guard u0 (.*);

    always #10 clk = ~clk;

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000 && !done) begin
            fails++;
            $display("FAIL watchdog: run hung, actual %0d cycles, expected < 5000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string r, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", r, what, act, exp);
        end
    endtask

    function automatic logic [63:0] mk(input int tg, input int idx, input int off, input logic [47:0] mid);
        return (64'(tg) << 60) | (64'(mid) << 12) | (64'(idx) << 6) | 64'(off);
    endfunction

    // One cycle: drive request at negedge, model it, compare at next negedge.
    task automatic step(input bit v, input int k, input logic [63:0] a, input bit te, input bit pe,
                        input bit ro, input bit pr, input int t, input bit clr, input string r);
        int idx, pt, lt, ecode, etype;
        bit egrant, dis, miss, wild;
        idx = int'(a[11:6]); pt = int'(a[63:60]); lt = m_tag[idx];
        ecode = 0; etype = 0; egrant = 1; dis = 0;
        wild = (pt == 0 || pt == 15 || lt == 0 || lt == 15);
        miss = !wild && (pt != lt);
        if (k == 0 && te && pe && miss) begin ecode = 1; etype = 'h1A; egrant = 0; end
        if (k == 1 && te && pe && miss) begin
            if (pr) begin ecode = 1; etype = 'h1A; egrant = 0; end
            else begin ecode = 2; etype = 'h7E; dis = 1; end
        end
        if (k == 3) begin
            if (!te) begin ecode = 3; etype = 'h0A; egrant = 0; end
            else if (ro || !pe) begin ecode = 4; egrant = 0; end
            else m_tag[idx] = t;
        end
        if (k == 4) begin
            if (ro) begin ecode = 4; egrant = 0; end
            else m_tag[idx] = 0;
        end
        if (v && dis && (!m_evld || clr)) begin m_evld = 1; m_eaddr = a; end
        else if (clr) m_evld = 0;
        req_valid = v; req_kind = 3'(k); req_addr = a; req_task_en = te; req_page_en = pe;
        req_page_ro = ro; req_precise = pr; req_tag = 4'(t); err_clr = clr;
        @(negedge clk);
        chk(rsp_valid == v, r, "rsp_valid", 64'(rsp_valid), 64'(v));
        if (v) begin
            chk(int'(rsp_code) == ecode, r, "rsp_code", 64'(rsp_code), 64'(ecode));
            chk(rsp_grant == egrant, r, "rsp_grant", 64'(rsp_grant), 64'(egrant));
            chk(int'(rsp_type) == etype, r, "rsp_type", 64'(rsp_type), 64'(etype));
            chk(rsp_addr == a, r, "rsp_addr", rsp_addr, a);
        end
        chk(err_vld == m_evld, r, "err_vld", 64'(err_vld), 64'(m_evld));
        if (m_evld) chk(err_addr == m_eaddr, r, "err_addr", err_addr, m_eaddr);
    endtask

    initial begin
        foreach (m_tag[i]) m_tag[i] = 0;
        repeat (3) @(negedge clk);
        // R1: reset state.
        chk(rsp_valid == 1'b0, "R1", "rsp_valid in reset", 64'(rsp_valid), 0);
        chk(err_vld == 1'b0, "R1", "err_vld in reset", 64'(err_vld), 0);
        rst_n = 1'b1;
        step(1, 0, mk(3, 5, 0, 48'h0), 1, 1, 0, 0, 0, 0, "R1");        // tags reset to 0
        step(1, 3, mk(0, 5, 0, 48'h0), 0, 1, 0, 0, 10, 0, "R9");       // disabled trap
        step(1, 0, mk(3, 5, 0, 48'h0), 1, 1, 0, 0, 0, 0, "R9");        // tag unchanged
        step(1, 3, mk(0, 5, 0, 48'h0), 1, 1, 1, 0, 10, 0, "R10");      // read-only page
        step(1, 3, mk(0, 5, 0, 48'h0), 1, 0, 0, 0, 10, 0, "R10");      // page enable off
        step(1, 0, mk(3, 5, 0, 48'h0), 1, 1, 0, 0, 0, 0, "R10");       // still 0
        step(1, 3, mk(0, 5, 0, 48'h0), 1, 1, 0, 0, 10, 0, "R11");      // write tag 0xA
        step(1, 0, mk(10, 5, 8, 48'h0), 1, 1, 0, 0, 0, 0, "R11");      // match next cycle
        step(1, 0, mk(3, 5, 0, 48'h0), 1, 1, 0, 0, 0, 0, "R7");        // load mismatch
        step(1, 0, mk(3, 5, 0, 48'h0), 1, 1, 0, 1, 0, 0, "R7");        // precise bit irrelevant
        step(1, 1, mk(3, 5, 4, 48'h0), 1, 1, 0, 0, 0, 0, "R5");        // disrupting store
        step(1, 1, mk(4, 5, 9, 48'h0), 1, 1, 0, 0, 0, 0, "R13");       // keeps first address
        step(1, 1, mk(3, 5, 0, 48'h0), 1, 1, 0, 1, 0, 0, "R6");        // precise store
        step(1, 0, mk(0, 5, 0, 48'h0), 1, 1, 0, 0, 0, 0, "R4");        // wildcard pointer 0
        step(1, 1, mk(15, 5, 0, 48'h0), 1, 1, 0, 1, 0, 0, "R4");       // wildcard pointer F
        step(1, 2, mk(3, 5, 0, 48'h0), 1, 1, 0, 1, 0, 0, "R8");        // non-faulting load
        step(1, 0, mk(3, 5, 0, 48'h0), 0, 1, 0, 0, 0, 0, "R3");        // task enable off
        step(1, 1, mk(3, 5, 0, 48'h0), 1, 0, 0, 1, 0, 0, "R3");        // page enable off
        step(1, 3, mk(0, 9, 0, 48'h0), 1, 1, 0, 0, 15, 0, "R4");       // stored wildcard F
        step(1, 0, mk(2, 9, 0, 48'h0), 1, 1, 0, 0, 0, 0, "R4");
        step(1, 0, mk(3, 5, 63, 48'hABCD_1234_5678), 1, 1, 0, 0, 0, 0, "R12"); // alias line 5
        step(1, 0, mk(10, 5, 1, 48'hFFFF_FFFF_FFFF), 1, 1, 0, 0, 0, 0, "R12");
        step(0, 0, mk(3, 5, 0, 48'h0), 1, 1, 0, 0, 0, 0, "R2");        // idle cycle
        step(0, 0, 64'h0, 0, 0, 0, 0, 0, 1, "R13");                    // clear record
        step(1, 1, mk(7, 5, 2, 48'h11), 1, 1, 0, 0, 0, 0, "R13");      // new record
        step(1, 1, mk(6, 5, 3, 48'h22), 1, 1, 0, 0, 0, 1, "R13");      // clear and set together
        step(1, 3, mk(0, 7, 0, 48'h0), 1, 1, 0, 0, 6, 0, "R11");
        step(1, 4, mk(0, 7, 0, 48'h0), 1, 1, 1, 0, 0, 0, "R10");       // blk-init read-only
        step(1, 0, mk(2, 7, 0, 48'h0), 1, 1, 0, 0, 0, 0, "R10");       // still 6: mismatch
        step(1, 4, mk(9, 5, 0, 48'h0), 0, 0, 0, 0, 0, 0, "R11");       // blk-init clears
        step(1, 0, mk(3, 5, 0, 48'h0), 1, 1, 0, 0, 0, 0, "R11");       // cleared: grant
        step(1, 1, mk(3, 7, 0, 48'h0), 1, 1, 0, 0, 0, 0, "R5");
        step(0, 0, 64'h0, 0, 0, 0, 0, 0, 0, "R2");
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule